// File: doc/BRIEF.md
# Saturating Accumulator Arithmetic Unit

This block holds a 16-bit accumulator and updates it once per accepted operation. Three operations are offered: add an operand, subtract an operand, and load a value taken from a product register. After every accepted operation it registers four condition flags alongside the new accumulator value: negative, signed overflow, zero and carry/borrow. The multiplier and the instruction decoder live outside; the decoder presents an opcode, an operand, the product value and two mode bits from the status word, and pulses a valid strobe.

Two mode bits shape the result. When saturation is enabled, an add or subtract whose signed result leaves the 16-bit range is clamped to the nearest representable extreme, yet the overflow flag is still raised. When the product-shift bit is clear, a loaded product is doubled (shifted one place left, zero into bit 0); when it is set, the product is taken unchanged.

The unit has no multi-cycle sequencing: a single registered stage samples the request on a rising clock edge and presents result and flags right after that edge, so operations can be issued back to back.

Top module: `accsat_alu`

## Requirements
- R1: While rst_n is low, and right after it is released, acc_q is 0x0000, flag_z is 1 and flag_n, flag_ov, flag_l are 0.
- R2: With in_valid high and opcode 2'b00 (add), acc_q takes acc_q + operand modulo 2^16 when no saturation applies, and flag_l is the carry out of bit 15 of the unsigned sum (0xFFFF + 0x0001 gives 0x0000 with flag_l = 1).
- R3: With in_valid high and opcode 2'b01 (subtract), acc_q takes acc_q − operand modulo 2^16 when no saturation applies, and flag_l is the borrow, i.e. 1 exactly when operand is larger than acc_q as unsigned numbers.
- R4: For add and subtract, flag_ov is 1 exactly when the true signed result lies outside −32768..32767 (0x7FFF + 0x0001 sets it); it is 0 otherwise.
- R5: With sat_en high, an overflowing add or subtract writes 0x7FFF when the true result is too large and 0x8000 when it is too small, and flag_ov is still 1; flag_l is unaffected by clamping.
- R6: flag_n equals bit 15 of the value written to acc_q and flag_z is 1 exactly when that written value is 0x0000, both taken after any clamping.
- R7: With opcode 2'b10 (product load), acc_q takes product shifted left by one with bit 0 cleared when macs is 0, or product unchanged when macs is 1; flag_ov and flag_l are cleared.
- R8: When in_valid is low, or opcode is 2'b11 (reserved), acc_q and all four flags keep their values.
- R9: An operation sampled at one rising edge is visible at the outputs before the next edge, and the following operation uses that result as its accumulator input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe; an operation is taken on each edge where it is high |
| opcode | input | 2 | 00 add, 01 subtract, 10 product load, 11 reserved |
| operand | input | 16 | Second operand of add and subtract |
| product | input | 16 | Product register value for the load operation |
| sat_en | input | 1 | Saturate signed overflow on add and subtract |
| macs | input | 1 | 0: double the loaded product, 1: load it unchanged |
| acc_q | output | 16 | Registered accumulator |
| flag_n | output | 1 | Negative flag |
| flag_ov | output | 1 | Signed overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_l | output | 1 | Carry (add) or borrow (subtract) flag |

## Verification
The only internal state is the accumulator and its flags, and both are ports, so a wrong update shows up at the edge right after the offending request. A wrong carry or overflow detector appears as a flag mismatch on the same cycle, while a wrong clamp direction shows as 0x7FFF where 0x8000 was due or the reverse. Because each result feeds the next operation, a corrupted accumulator also spreads into every later result until a product load overwrites it.

// File: rtl/accsat_pkg.sv
package accsat_pkg;

    localparam int unsigned ACC_W = 16;

    typedef enum logic [1:0] {
        OPC_ADD = 2'd0,
        OPC_SUB = 2'd1,
        OPC_LDP = 2'd2,
        OPC_RSV = 2'd3
    } opc_e;

    typedef struct packed {
        logic n;
        logic ov;
        logic z;
        logic l;
    } flags_t;

endpackage

// File: rtl/accsat_addsub.sv
module accsat_addsub #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] opnd,
    input  logic         is_sub,
    output logic [W-1:0] raw,
    output logic         carry,
    output logic         ovf
);
    localparam int unsigned MSB = W - 1;

    logic [W:0] wide;

    always_comb begin
        if (is_sub) begin
            wide = {1'b0, acc_in} - {1'b0, opnd};
            ovf  = (acc_in[MSB] != opnd[MSB]) && (wide[MSB] != acc_in[MSB]);
        end else begin
            wide = {1'b0, acc_in} + {1'b0, opnd};
            ovf  = (acc_in[MSB] == opnd[MSB]) && (wide[MSB] != acc_in[MSB]);
        end
        raw   = wide[W-1:0];
        carry = wide[W];
    end
endmodule

// File: rtl/accsat_prodsel.sv
module accsat_prodsel #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] product,
    input  logic         macs,
    output logic [W-1:0] loaded
);
    always_comb begin
        if (macs) loaded = product;
        else      loaded = {product[W-2:0], 1'b0};
    end
endmodule

// File: rtl/accsat_clamp.sv
module accsat_clamp #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] raw,
    input  logic         ovf,
    input  logic         sat_en,
    input  logic         acc_sign,
    output logic [W-1:0] result
);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    // An overflow always moves away from the accumulator's own sign,
    // so that sign picks which extreme to clamp to.
    always_comb begin
        if (sat_en && ovf) result = acc_sign ? NEG_MIN : POS_MAX;
        else               result = raw;
    end
endmodule

// File: rtl/accsat_alu.sv
module accsat_alu
    import accsat_pkg::*;
#(
    parameter int unsigned W = ACC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   opcode,
    input  logic [W-1:0] operand,
    input  logic [W-1:0] product,
    input  logic         sat_en,
    input  logic         macs,
    output logic [W-1:0] acc_q,
    output logic         flag_n,
    output logic         flag_ov,
    output logic         flag_z,
    output logic         flag_l
);
    localparam int unsigned MSB = W - 1;
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    opc_e         opc;
    logic [W-1:0] raw_val, clamped, loaded, acc_d;
    logic         carry, ovf, take;
    flags_t       flg_q, flg_d;

    assign opc = opc_e'(opcode);

    accsat_addsub #(.W(W)) u_addsub (
        .acc_in (acc_q),
        .opnd   (operand),
        .is_sub (opc == OPC_SUB),
        .raw    (raw_val),
        .carry  (carry),
        .ovf    (ovf)
    );

    accsat_clamp #(.W(W)) u_clamp (
        .raw      (raw_val),
        .ovf      (ovf),
        .sat_en   (sat_en),
        .acc_sign (acc_q[MSB]),
        .result   (clamped)
    );

    accsat_prodsel #(.W(W)) u_prodsel (
        .product (product),
        .macs    (macs),
        .loaded  (loaded)
    );

    always_comb begin
        take  = in_valid;
        acc_d = acc_q;
        flg_d = flg_q;
        unique case (opc)
            OPC_ADD, OPC_SUB: begin
                acc_d = clamped;
                flg_d = '{n: clamped[MSB], ov: ovf, z: (clamped == '0), l: carry};
            end
            OPC_LDP: begin
                acc_d = loaded;
                flg_d = '{n: loaded[MSB], ov: 1'b0, z: (loaded == '0), l: 1'b0};
            end
            OPC_RSV: take = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            flg_q <= '{n: 1'b0, ov: 1'b0, z: 1'b1, l: 1'b0};
        end else if (take) begin
            acc_q <= acc_d;
            flg_q <= flg_d;
        end
    end

    assign flag_n  = flg_q.n;
    assign flag_ov = flg_q.ov;
    assign flag_z  = flg_q.z;
    assign flag_l  = flg_q.l;

    // R6: zero and negative flags agree with the stored accumulator
    assert_zero_tracks_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_z == (acc_q == '0)) && (flag_n == acc_q[MSB]));

    // R8: idle or reserved requests leave the state untouched
    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || opcode == 2'b11) |=> ($stable(acc_q) && $stable(flg_q)));

    // R5: a saturated overflow lands on one of the two extremes
    assert_clamp_extreme_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_en && !opcode[1]) |=>
            (!flag_ov || acc_q == POS_MAX || acc_q == NEG_MIN));

    // R7: product loads clear overflow and carry
    assert_load_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 2'b10) |=> (!flag_ov && !flag_l));

    // R4: adding zero never overflows
    assert_add_zero_no_ov_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 2'b00 && operand == '0) |=> !flag_ov);

endmodule

// File: tb/accsat_alu_tb.sv
module accsat_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  opcode = 2'b00;
    logic [15:0] operand = '0;
    logic [15:0] product = '0;
    logic        sat_en = 1'b0;
    logic        macs = 1'b0;
    logic [15:0] acc_q;
    logic        flag_n, flag_ov, flag_z, flag_l;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    accsat_alu dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .operand(operand), .product(product), .sat_en(sat_en), .macs(macs),
        .acc_q(acc_q), .flag_n(flag_n), .flag_ov(flag_ov), .flag_z(flag_z),
        .flag_l(flag_l)
    );

    // fields: req[4] a[16] code[2] b[16] sat[1] macs[1] exp[16] flags{N,OV,Z,L}[4]
    localparam int NV = 15;
    localparam logic [59:0] VECS [0:NV-1] = '{
        {4'd2, 16'h1234, 2'd0, 16'h0001, 1'b0, 1'b0, 16'h1235, 4'b0000}, // R2
        {4'd2, 16'hFFFF, 2'd0, 16'h0001, 1'b0, 1'b0, 16'h0000, 4'b0011}, // R2 carry
        {4'd3, 16'h0000, 2'd1, 16'h0001, 1'b0, 1'b0, 16'hFFFF, 4'b1001}, // R3 borrow
        {4'd3, 16'h0005, 2'd1, 16'h0003, 1'b0, 1'b0, 16'h0002, 4'b0000}, // R3
        {4'd4, 16'h7FFF, 2'd0, 16'h0001, 1'b0, 1'b0, 16'h8000, 4'b1100}, // R4
        {4'd4, 16'h8000, 2'd1, 16'h0001, 1'b0, 1'b0, 16'h7FFF, 4'b0100}, // R4
        {4'd5, 16'h7FFF, 2'd0, 16'h0001, 1'b1, 1'b0, 16'h7FFF, 4'b0100}, // R5
        {4'd5, 16'h8000, 2'd1, 16'h0001, 1'b1, 1'b0, 16'h8000, 4'b1100}, // R5
        {4'd5, 16'h8000, 2'd0, 16'hFFFF, 1'b1, 1'b0, 16'h8000, 4'b1101}, // R5 with carry
        {4'd3, 16'h7FFF, 2'd1, 16'hFFFF, 1'b1, 1'b0, 16'h7FFF, 4'b0101}, // R3 clamp + borrow
        {4'd6, 16'h8000, 2'd0, 16'h8000, 1'b0, 1'b0, 16'h0000, 4'b0111}, // R6
        {4'd6, 16'h0003, 2'd1, 16'h0003, 1'b0, 1'b0, 16'h0000, 4'b0010}, // R6
        {4'd7, 16'h1111, 2'd2, 16'h4001, 1'b0, 1'b0, 16'h8002, 4'b1000}, // R7 doubled
        {4'd7, 16'h1111, 2'd2, 16'h4001, 1'b0, 1'b1, 16'h4001, 4'b0000}, // R7 as is
        {4'd7, 16'h1111, 2'd2, 16'h8000, 1'b0, 1'b0, 16'h0000, 4'b0010}  // R7 shifted out
    };

    task automatic check(input int req, input logic [15:0] exp_acc, input logic [3:0] exp_fl);
        logic [3:0] fl;
        fl = {flag_n, flag_ov, flag_z, flag_l};
        n_chk++;
        if (acc_q !== exp_acc || fl !== exp_fl) begin
            n_bad++;
            $display("FAIL R%0d: acc=%h flags=%b expected acc=%h flags=%b",
                     req, acc_q, fl, exp_acc, exp_fl);
        end
    endtask

    task automatic issue(input logic v, input logic [1:0] c, input logic [15:0] b,
                         input logic [15:0] p, input logic s, input logic m);
        in_valid = v; opcode = c; operand = b; product = p; sat_en = s; macs = m;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1, 16'h0000, 4'b0010);             // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 16'h0000, 4'b0010);             // R1 after release

        for (int i = 0; i < NV; i++) begin
            logic [59:0] v;
            v = VECS[i];
            issue(1'b1, 2'd2, 16'h0, v[55:40], 1'b0, 1'b1);   // preload a
            issue(1'b1, v[39:38], v[37:22], v[37:22], v[21], v[20]);
            check(int'(v[59:56]), v[19:4], v[3:0]);
        end

        // R8: valid low ignores an add
        issue(1'b1, 2'd2, 16'h0, 16'h8001, 1'b0, 1'b1);
        issue(1'b0, 2'd0, 16'h0001, 16'h0, 1'b0, 1'b0);
        check(8, 16'h8001, 4'b1000);
        // R8: reserved opcode with valid high
        issue(1'b1, 2'd3, 16'h0001, 16'h1234, 1'b1, 1'b0);
        check(8, 16'h8001, 4'b1000);

        // R9: back-to-back chain, each result visible before the next edge
        issue(1'b1, 2'd2, 16'h0, 16'h0010, 1'b0, 1'b1);
        in_valid = 1'b1; opcode = 2'd0; operand = 16'h0001; sat_en = 1'b0;
        @(posedge clk); @(negedge clk);
        check(9, 16'h0011, 4'b0000);
        opcode = 2'd1; operand = 16'h0012;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        check(9, 16'hFFFF, 4'b1001);

        // R1: reset mid-run restores the cleared state
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(1, 16'h0000, 4'b0010);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule